// File: doc/BRIEF.md
# Bitwise-Mismatch Packet Route Selector

This block picks the outgoing link for a packet header arriving at a switch node. It XORs the 16-bit destination address with the local node identifier and looks for the highest-order bit where they disagree. The position of that bit indexes a 16-entry direction table, and the 4-bit direction code found there is then resolved to a link. Every one of the eight outgoing links is tied to exactly one direction. The selector grants the lowest-numbered link that carries that direction and is not already carrying a stream.

A destination equal to the node identifier is not routed: the block raises a one-cycle local-delivery pulse instead. A granted link stays busy until its stream-end input is pulsed. A request that finds no eligible free link stays pending while the requester holds it, and is retried every cycle. A small configuration port holds the node identifier, the direction table (packed into two 32-bit words) and one configuration word per link carrying its direction and logical network number.

Top module: `mismatch_route_sel`

## Requirements
- R1: After reset no link is busy, grant_valid and local_hit are low, and the node identifier, table words and link words all read as zero.
- R2: A write to address 0x00 stores bits 15:0 of the data as the node identifier. A read of 0x00 returns the identifier in bits 15:0 and zero in bits 31:16.
- R3: Direction table entry k (4 bits) is stored at address 0x0C bits 4k+3:4k for k = 0..7, and at address 0x0D bits 4(k-8)+3:4(k-8) for k = 8..15. Both words read back exactly as written.
- R4: The word for link i is at address 0x10+i. Bits 5:4 hold its network number and bits 9:7 hold its 3-bit direction. Every other bit, including bit 10, reads zero, and any unmapped address reads zero.
- R5: When req_valid is sampled high and req_dest equals the node identifier, local_hit is high for the following cycle, grant_valid stays low and no link changes to busy.
- R6: Otherwise the routing index is the highest bit position at which req_dest and the node identifier differ. The wanted direction is table entry [index].
- R7: A link is eligible when it is free and its 3-bit direction, zero-extended to 4 bits, equals the wanted direction; a table entry of 8 or more therefore never matches. On an accepting edge, grant_valid is high for the next cycle, with grant_link set to the link index and grant_net set to that link's network number.
- R8: When several links are eligible, the one with the lowest index is granted.
- R9: With no eligible link, nothing is granted and the held request is retried on every edge. It is granted on the edge after the one at which a matching link is freed.
- R10: A granted link is busy from the grant edge until an edge at which its link_end bit is high. A link_end pulse on a free link has no effect.
- R11: On the edge immediately after a grant or local-delivery pulse, req_valid is ignored. A request held continuously therefore gives pulses on alternate cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational on cfg_addr) |
| req_valid | input | 1 | Routing request present; held until grant or local pulse |
| req_dest | input | 16 | Destination node address of the request |
| link_end | input | 8 | Per-link stream-end pulse, frees the link |
| grant_valid | output | 1 | One-cycle pulse: a link was granted |
| grant_link | output | 3 | Index of the granted link |
| grant_net | output | 2 | Network number of the granted link |
| local_hit | output | 1 | One-cycle pulse: request addressed to this node |
| link_busy | output | 8 | Per-link busy state |

## Verification
The bench sweeps every mismatch position under several node identifiers, and sets the bits below the first difference to mixed values. A priority encoder that picked the lowest differing bit, or that let lower bits take part, would grant the wrong link. Several links share one direction so that the lowest-index choice is checked, and a request is then held against all-busy links. A design that re-granted a busy link, or that took the freed link on the same edge as the stream end, would be caught there. Further checks cover a table entry above seven that must never match and a held local request that must pulse on alternate cycles. They also cover link words whose spare bits must read zero.

// File: rtl/route_sel_pkg.sv
package route_sel_pkg;
  localparam int NODE_W     = 16;
  localparam int DIR_W      = 4;
  localparam int LDIR_W     = 3;
  localparam int NET_W      = 2;
  localparam int NUM_LINKS  = 8;
  localparam int CFG_AW     = 5;
  localparam int DATA_W     = 32;

  // configuration address map
  localparam int OFS_NODE   = 'h00;
  localparam int OFS_TBL    = 'h0C;
  localparam int OFS_LINK   = 'h10;

  // link word field positions
  localparam int NET_LSB    = 4;
  localparam int LDIR_LSB   = 7;
endpackage

// File: rtl/route_cfg_regs.sv
module route_cfg_regs
  import route_sel_pkg::*;
#(
  parameter int P_NODE_W    = NODE_W,
  parameter int P_DIR_W     = DIR_W,
  parameter int P_LDIR_W    = LDIR_W,
  parameter int P_NET_W     = NET_W,
  parameter int P_NUM_LINKS = NUM_LINKS,
  parameter int P_CFG_AW    = CFG_AW,
  parameter int P_DATA_W    = DATA_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [P_CFG_AW-1:0]               cfg_addr,
  input  logic [P_DATA_W-1:0]               cfg_wdata,
  output logic [P_DATA_W-1:0]               cfg_rdata,
  output logic [P_NODE_W-1:0]               node_id,
  output logic [P_NODE_W*P_DIR_W-1:0]       dir_tbl,
  output logic [P_NUM_LINKS*P_LDIR_W-1:0]   link_dir,
  output logic [P_NUM_LINKS*P_NET_W-1:0]    link_net
);
  localparam int TBL_BITS  = P_NODE_W * P_DIR_W;
  localparam int TBL_WORDS = (TBL_BITS + P_DATA_W - 1) / P_DATA_W;
  localparam int TBL_PAD   = TBL_WORDS * P_DATA_W;

  logic [TBL_PAD-1:0] tbl_q;

  function automatic logic addr_is(input logic [P_CFG_AW-1:0] a, input int ofs);
    return a == P_CFG_AW'(ofs);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) node_id <= '0;
    else if (cfg_we && addr_is(cfg_addr, OFS_NODE)) node_id <= cfg_wdata[P_NODE_W-1:0];
  end

  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rst_n) tbl_q[w*P_DATA_W +: P_DATA_W] <= '0;
      else if (cfg_we && addr_is(cfg_addr, OFS_TBL + w))
        tbl_q[w*P_DATA_W +: P_DATA_W] <= cfg_wdata;
    end
  end
  assign dir_tbl = tbl_q[TBL_BITS-1:0];

  for (genvar i = 0; i < P_NUM_LINKS; i++) begin : g_link
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        link_dir[i*P_LDIR_W +: P_LDIR_W] <= '0;
        link_net[i*P_NET_W +: P_NET_W]   <= '0;
      end else if (cfg_we && addr_is(cfg_addr, OFS_LINK + i)) begin
        link_dir[i*P_LDIR_W +: P_LDIR_W] <= cfg_wdata[LDIR_LSB +: P_LDIR_W];
        link_net[i*P_NET_W +: P_NET_W]   <= cfg_wdata[NET_LSB +: P_NET_W];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (addr_is(cfg_addr, OFS_NODE)) cfg_rdata[P_NODE_W-1:0] = node_id;
    for (int w = 0; w < TBL_WORDS; w++)
      if (addr_is(cfg_addr, OFS_TBL + w)) cfg_rdata = tbl_q[w*P_DATA_W +: P_DATA_W];
    for (int i = 0; i < P_NUM_LINKS; i++)
      if (addr_is(cfg_addr, OFS_LINK + i)) begin
        cfg_rdata[LDIR_LSB +: P_LDIR_W] = link_dir[i*P_LDIR_W +: P_LDIR_W];
        cfg_rdata[NET_LSB +: P_NET_W]   = link_net[i*P_NET_W +: P_NET_W];
      end
  end
endmodule

// File: rtl/route_dir_lookup.sv
module route_dir_lookup
  import route_sel_pkg::*;
#(
  parameter int P_NODE_W = NODE_W,
  parameter int P_DIR_W  = DIR_W,
  localparam int IDX_W   = $clog2(P_NODE_W)
) (
  input  logic [P_NODE_W-1:0]         node_id,
  input  logic [P_NODE_W-1:0]         dest,
  input  logic [P_NODE_W*P_DIR_W-1:0] dir_tbl,
  output logic                        is_local,
  output logic [IDX_W-1:0]            mis_idx,
  output logic [P_DIR_W-1:0]          want_dir
);
  // highest set bit of the difference vector (scan upward, last hit wins)
  function automatic logic [IDX_W-1:0] top_one(input logic [P_NODE_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int b = 0; b < P_NODE_W; b++)
      if (v[b]) r = IDX_W'(b);
    return r;
  endfunction

  logic [P_NODE_W-1:0] diff;

  assign diff     = dest ^ node_id;
  assign is_local = (diff == '0);
  assign mis_idx  = top_one(diff);
  assign want_dir = dir_tbl[mis_idx*P_DIR_W +: P_DIR_W];
endmodule

// File: rtl/route_link_arbiter.sv
module route_link_arbiter
  import route_sel_pkg::*;
#(
  parameter int P_DIR_W     = DIR_W,
  parameter int P_LDIR_W    = LDIR_W,
  parameter int P_NET_W     = NET_W,
  parameter int P_NUM_LINKS = NUM_LINKS,
  localparam int LIDX_W     = $clog2(P_NUM_LINKS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            is_local,
  input  logic [P_DIR_W-1:0]              want_dir,
  input  logic [P_NUM_LINKS*P_LDIR_W-1:0] link_dir,
  input  logic [P_NUM_LINKS*P_NET_W-1:0]  link_net,
  input  logic [P_NUM_LINKS-1:0]          link_end,
  output logic [P_NUM_LINKS-1:0]          cand_mask,
  output logic                            take_link,
  output logic                            take_local,
  output logic                            grant_valid,
  output logic [LIDX_W-1:0]               grant_link,
  output logic [P_NET_W-1:0]              grant_net,
  output logic                            local_hit,
  output logic [P_NUM_LINKS-1:0]          link_busy
);
  function automatic logic [LIDX_W-1:0] low_one(input logic [P_NUM_LINKS-1:0] m);
    logic [LIDX_W-1:0] r;
    r = '0;
    for (int i = P_NUM_LINKS - 1; i >= 0; i--)
      if (m[i]) r = LIDX_W'(i);
    return r;
  endfunction

  logic                   cooldown;
  logic [LIDX_W-1:0]      pick;
  logic [P_NUM_LINKS-1:0] pick_oh;

  for (genvar i = 0; i < P_NUM_LINKS; i++) begin : g_cand
    assign cand_mask[i] = !link_busy[i] &&
      (P_DIR_W'(link_dir[i*P_LDIR_W +: P_LDIR_W]) == want_dir);
  end

  assign cooldown   = grant_valid | local_hit;
  assign take_local = req_valid && !cooldown && is_local;
  assign take_link  = req_valid && !cooldown && !is_local && (cand_mask != '0);
  assign pick       = low_one(cand_mask);
  assign pick_oh    = take_link ? (P_NUM_LINKS'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_link  <= '0;
      grant_net   <= '0;
      local_hit   <= 1'b0;
      link_busy   <= '0;
    end else begin
      grant_valid <= take_link;
      grant_link  <= take_link ? pick : '0;
      grant_net   <= take_link ? link_net[pick*P_NET_W +: P_NET_W] : '0;
      local_hit   <= take_local;
      link_busy   <= (link_busy & ~link_end) | pick_oh;
    end
  end
endmodule

// File: rtl/mismatch_route_sel.sv
module mismatch_route_sel
  import route_sel_pkg::*;
#(
  parameter int P_NODE_W    = NODE_W,
  parameter int P_DIR_W     = DIR_W,
  parameter int P_LDIR_W    = LDIR_W,
  parameter int P_NET_W     = NET_W,
  parameter int P_NUM_LINKS = NUM_LINKS,
  parameter int P_CFG_AW    = CFG_AW,
  parameter int P_DATA_W    = DATA_W,
  localparam int LIDX_W     = $clog2(P_NUM_LINKS),
  localparam int IDX_W      = $clog2(P_NODE_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [P_CFG_AW-1:0]    cfg_addr,
  input  logic [P_DATA_W-1:0]    cfg_wdata,
  output logic [P_DATA_W-1:0]    cfg_rdata,
  input  logic                   req_valid,
  input  logic [P_NODE_W-1:0]    req_dest,
  input  logic [P_NUM_LINKS-1:0] link_end,
  output logic                   grant_valid,
  output logic [LIDX_W-1:0]      grant_link,
  output logic [P_NET_W-1:0]     grant_net,
  output logic                   local_hit,
  output logic [P_NUM_LINKS-1:0] link_busy
);
  logic [P_NODE_W-1:0]              node_id;
  logic [P_NODE_W*P_DIR_W-1:0]      dir_tbl;
  logic [P_NUM_LINKS*P_LDIR_W-1:0]  link_dir;
  logic [P_NUM_LINKS*P_NET_W-1:0]   link_net;
  logic                             is_local;
  logic [IDX_W-1:0]                 mis_idx;
  logic [P_DIR_W-1:0]               want_dir;
  logic [P_NUM_LINKS-1:0]           cand_mask;
  logic                             take_link;
  logic                             take_local;

  route_cfg_regs #(
    .P_NODE_W(P_NODE_W), .P_DIR_W(P_DIR_W), .P_LDIR_W(P_LDIR_W), .P_NET_W(P_NET_W),
    .P_NUM_LINKS(P_NUM_LINKS), .P_CFG_AW(P_CFG_AW), .P_DATA_W(P_DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .node_id(node_id),
    .dir_tbl(dir_tbl), .link_dir(link_dir), .link_net(link_net)
  );

  route_dir_lookup #(.P_NODE_W(P_NODE_W), .P_DIR_W(P_DIR_W)) u_lookup (
    .node_id(node_id), .dest(req_dest), .dir_tbl(dir_tbl),
    .is_local(is_local), .mis_idx(mis_idx), .want_dir(want_dir)
  );

  route_link_arbiter #(
    .P_DIR_W(P_DIR_W), .P_LDIR_W(P_LDIR_W), .P_NET_W(P_NET_W), .P_NUM_LINKS(P_NUM_LINKS)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_local(is_local),
    .want_dir(want_dir), .link_dir(link_dir), .link_net(link_net),
    .link_end(link_end), .cand_mask(cand_mask), .take_link(take_link),
    .take_local(take_local), .grant_valid(grant_valid), .grant_link(grant_link),
    .grant_net(grant_net), .local_hit(local_hit), .link_busy(link_busy)
  );
endmodule

// File: rtl/mismatch_route_sel_chk.sv
module mismatch_route_sel_chk #(
  parameter int P_NUM_LINKS = 8,
  parameter int P_CFG_AW    = 5,
  parameter int P_DATA_W    = 32,
  parameter int P_NODE_W    = 16,
  localparam int LIDX_W     = $clog2(P_NUM_LINKS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [P_CFG_AW-1:0]    cfg_addr,
  input logic [P_DATA_W-1:0]    cfg_rdata,
  input logic [P_NUM_LINKS-1:0] link_end,
  input logic                   grant_valid,
  input logic [LIDX_W-1:0]      grant_link,
  input logic                   local_hit,
  input logic [P_NUM_LINKS-1:0] link_busy,
  input logic [P_NUM_LINKS-1:0] cand_mask
);
  logic [P_NUM_LINKS-1:0] busy_q;
  logic [P_NUM_LINKS-1:0] cand_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      cand_q <= '0;
    end else begin
      busy_q <= link_busy;
      cand_q <= cand_mask;
    end
  end

  // R2: upper half of the node identifier word reads zero
  p_node_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == '0) |-> (cfg_rdata[P_DATA_W-1:P_NODE_W] == '0));

  // R5: local delivery and grant never coincide
  p_local_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && local_hit));

  // R5: local delivery marks no link busy
  p_local_no_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    local_hit |-> (link_busy == ($past(link_busy) & ~$past(link_end))));

  // R7: granted link was free before the grant edge
  p_grant_was_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !busy_q[grant_link]);

  // R8: no lower-index eligible link was passed over
  p_lowest_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ((cand_q & ~({P_NUM_LINKS{1'b1}} << grant_link)) == '0));

  // R10: granted link is busy
  p_grant_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> link_busy[grant_link]);

  // R10: busy only clears through link_end
  for (genvar i = 0; i < P_NUM_LINKS; i++) begin : g_hold
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (link_busy[i] && !link_end[i]) |=> link_busy[i]);
  end

  // R11: no pulse on the cycle after a pulse
  p_cooldown_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid || local_hit) |=> !(grant_valid || local_hit));
endmodule

bind mismatch_route_sel mismatch_route_sel_chk #(
  .P_NUM_LINKS(P_NUM_LINKS), .P_CFG_AW(P_CFG_AW), .P_DATA_W(P_DATA_W), .P_NODE_W(P_NODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .link_end(link_end), .grant_valid(grant_valid), .grant_link(grant_link),
  .local_hit(local_hit), .link_busy(link_busy), .cand_mask(cand_mask)
);

// File: tb/mismatch_route_sel_bench.sv
`timescale 1ns/1ps
module mismatch_route_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [15:0] req_dest = '0;
  logic [7:0]  link_end = '0;
  logic        grant_valid;
  logic [2:0]  grant_link;
  logic [1:0]  grant_net;
  logic        local_hit;
  logic [7:0]  link_busy;

  int checks = 0;
  int errors = 0;

  // bench-side model of configuration and busy state
  logic [3:0]  m_tbl [16];
  logic [2:0]  m_dir [8];
  logic [1:0]  m_net [8];
  logic [15:0] m_node;

  always #2.5 clk = ~clk;

  mismatch_route_sel u_mismatch_route_sel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_dest(req_dest), .link_end(link_end), .grant_valid(grant_valid),
    .grant_link(grant_link), .grant_net(grant_net), .local_hit(local_hit),
    .link_busy(link_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [31:0] tbl_word(input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 8; k++) r[k*4 +: 4] = m_tbl[w*8 + k];
    return r;
  endfunction

  task automatic load_cfg();
    wr(5'h00, {16'hBEEF, m_node});
    wr(5'h0C, tbl_word(0));
    wr(5'h0D, tbl_word(1));
    for (int i = 0; i < 8; i++)
      wr(5'(16 + i), (32'(m_dir[i]) << 7) | (32'(m_net[i]) << 4));
  endtask

  // expected link for dest given busy mask: -1 none, -2 local
  function automatic int exp_route(input logic [15:0] d, input logic [7:0] busy);
    logic [15:0] x = d ^ m_node;
    int top = -1;
    logic [3:0] want;
    if (x == 0) return -2;
    for (int b = 15; b >= 0; b--) if (x[b] && top < 0) top = b;
    want = m_tbl[top];
    for (int i = 0; i < 8; i++)
      if (!busy[i] && {1'b0, m_dir[i]} == want) return i;
    return -1;
  endfunction

  // one request held across a single edge, sampled at the next negedge
  task automatic req_once(input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_dest = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic end_pulse(input logic [7:0] m);
    @(negedge clk);
    link_end = m;
    @(negedge clk);
    link_end = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int e;
    logic [15:0] nodes [3];
    nodes[0] = 16'h0000; nodes[1] = 16'hA5C3; nodes[2] = 16'hFFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 busy", 32'(link_busy), 0);
    chk("R1 grant_valid", 32'(grant_valid), 0);
    chk("R1 local_hit", 32'(local_hit), 0);
    rd(5'h00, rv); chk("R1 node", rv, 0);
    rd(5'h0C, rv); chk("R1 tbl lo", rv, 0);
    rd(5'h0D, rv); chk("R1 tbl hi", rv, 0);
    rd(5'h13, rv); chk("R1 link3", rv, 0);

    // R2: node id keeps only the low half
    wr(5'h00, 32'hABCD_1234);
    rd(5'h00, rv); chk("R2 node readback", rv, 32'h0000_1234);

    // R3: table words
    wr(5'h0C, 32'h8765_4321);
    wr(5'h0D, 32'hFEDC_BA98);
    rd(5'h0C, rv); chk("R3 tbl 0x0C", rv, 32'h8765_4321);
    rd(5'h0D, rv); chk("R3 tbl 0x0D", rv, 32'hFEDC_BA98);

    // R4: link word fields and spare bits
    wr(5'h15, 32'hFFFF_FFFF);
    rd(5'h15, rv); chk("R4 link5 fields", rv, 32'h0000_03B0);
    rd(5'h05, rv); chk("R4 unmapped 0x05", rv, 0);
    rd(5'h1F, rv); chk("R4 unmapped 0x1F", rv, 0);

    // R6/R7 sweep: each mismatch position, varied low bits
    for (int i = 0; i < 8; i++) begin m_dir[i] = 3'(i); m_net[i] = 2'(i % 4); end
    for (int k = 0; k < 16; k++) m_tbl[k] = 4'((k * 3 + 1) % 8);
    foreach (nodes[n]) begin
      m_node = nodes[n];
      load_cfg();
      for (int k = 0; k < 16; k++) begin
        logic [15:0] d;
        d = m_node ^ (16'(1) << k) ^ ((16'(1) << k) - 16'd1 & (16'h5A5A ^ 16'(n * 16'h1111)));
        e = exp_route(d, 8'h00);
        req_once(d);
        chk("R6 R7 grant_valid", 32'(grant_valid), 1);
        chk("R6 R7 grant_link", 32'(grant_link), 32'(e));
        chk("R7 grant_net", 32'(grant_net), 32'(m_net[e]));
        chk("R10 busy after grant", 32'(link_busy), 32'(8'(1) << e));
        end_pulse(8'(1) << e);
        chk("R10 freed by end", 32'(link_busy), 0);
      end
    end

    // R5: local delivery
    req_once(m_node);
    chk("R5 local_hit", 32'(local_hit), 1);
    chk("R5 no grant", 32'(grant_valid), 0);
    chk("R5 no busy", 32'(link_busy), 0);

    // R11: held local request pulses on alternate cycles
    @(negedge clk);
    req_valid = 1'b1; req_dest = m_node;
    @(negedge clk); chk("R11 pulse 1", 32'(local_hit), 1);
    @(negedge clk); chk("R11 cooldown", 32'(local_hit), 0);
    @(negedge clk); chk("R11 pulse 2", 32'(local_hit), 1);
    req_valid = 1'b0;
    @(negedge clk);

    // R8/R9: links 2,5,6 share direction 3
    m_node = 16'h0000;
    m_dir[0] = 0; m_dir[1] = 1; m_dir[2] = 3; m_dir[3] = 4;
    m_dir[4] = 4; m_dir[5] = 3; m_dir[6] = 3; m_dir[7] = 7;
    m_tbl[15] = 4'd3;
    m_tbl[14] = 4'd9;
    load_cfg();
    req_once(16'h8000); chk("R8 first lowest", 32'(grant_link), 2);
    req_once(16'h8123); chk("R8 second", 32'(grant_link), 5);
    req_once(16'h8FFF); chk("R8 third", 32'(grant_link), 6);
    chk("R8 busy set", 32'(link_busy), 32'h64);
    chk("R8 net of 6", 32'(grant_net), 2);

    @(negedge clk);
    req_valid = 1'b1; req_dest = 16'h8000;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); chk("R9 pending no grant", 32'(grant_valid), 0);
    end
    link_end = 8'h20;
    @(negedge clk);
    link_end = 8'h00;
    chk("R9 not same edge as end", 32'(grant_valid), 0);
    chk("R9 link5 freed", 32'(link_busy), 32'h44);
    @(negedge clk);
    chk("R9 retried grant", 32'(grant_valid), 1);
    chk("R9 retried link", 32'(grant_link), 5);
    req_valid = 1'b0;
    end_pulse(8'hFF);
    chk("R10 all freed", 32'(link_busy), 0);

    // R10: stream end on a free link is ignored
    req_once(16'h8000);
    chk("R10 grant link2", 32'(grant_link), 2);
    end_pulse(8'h01);
    chk("R10 end on free link", 32'(link_busy), 32'h04);
    end_pulse(8'h04);

    // R7: table entry 9 never matches a 3-bit link direction
    @(negedge clk);
    req_valid = 1'b1; req_dest = 16'h4000;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); chk("R7 entry above 7 no grant", 32'(grant_valid), 0);
    end
    req_valid = 1'b0;
    chk("R7 entry above 7 busy", 32'(link_busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule